// File: doc/BRIEF.md
# NAND Block Erase Sequencer

This controller erases one block of a NAND flash device each time it is asked to. A host raises `start_i` for one cycle and presents a row address. The sequencer writes the erase-setup command and then three row-address bytes, least significant byte first, with the page-select bits forced to zero. It then writes the confirm command, which starts the erase inside the device.

Two completion modes are offered, and the mode is chosen when the operation starts. In pin mode the sequencer watches the synchronized ready/busy pin. It waits for the pin to fall and then to rise again, and only then issues one status read. In polling mode it waits a programmable number of cycles and then reads status. It repeats this until the ready flag in the status byte is set. In both modes the fail flag of the final status byte is reported on `fail_o`, together with a one-cycle `done_o` pulse. A new request that arrives while an operation is running is ignored.

Top module: `erase_seq`

## Requirements
- R1: The first byte latched by a rising `nand_we_no` after a start is command 0x60, with `nand_cle_o` high and `nand_ale_o` low.
- R2: Exactly three address bytes follow, each with `nand_ale_o` high and `nand_cle_o` low. They carry the latched row address in order: bits 7:0 first, then bits 15:8, then bits 23:16.
- R3: Row-address bits 5:0 are driven as zero on the bus, whatever value they had on `row_addr_i`.
- R4: Command 0xD0 is latched directly after the third address byte. It is latched only there, so an operation writes the bytes 0x60, three address bytes, 0xD0, and after that only status commands.
- R5: In pin mode (`mode_poll_i`=0), exactly one status command 0x70 is written. It is written only after `nand_rb_ni` has been low and has returned high, and never while the device is busy.
- R6: In polling mode (`mode_poll_i`=1), status is read after at least `poll_gap_i` idle cycles (a value of 0 counts as 1). The read is repeated while status bit 6 (ready) is 0, with at least that gap before each new 0x70.
- R7: `fail_o` equals status bit 0 of the status byte that ends the operation (1 means fail). It is valid while `done_o` is high and holds its value until the next accepted start.
- R8: `done_o` is a single-cycle pulse while `busy_o` is high. `busy_o` rises the cycle after an accepted start and falls the cycle after `done_o`. After reset both are low.
- R9: A `start_i` pulse while `busy_o` is high has no effect. The address and the command sequence of the running operation are unchanged, and no second operation follows.
- R10: `nand_cle_o` and `nand_ale_o` are never high together. `nand_we_no` and `nand_re_no` are never low together. `nand_io_oe_o` is low whenever `nand_re_no` is low. After reset both strobes are high and both latch enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request pulse, accepted when idle |
| row_addr_i | input | 24 | Row address of the block to erase |
| mode_poll_i | input | 1 | 1: poll status, 0: wait on ready/busy pin |
| poll_gap_i | input | 8 | Cycles between status polls |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fail_o | output | 1 | Erase result, 1 = fail |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_we_no | output | 1 | Write strobe, active low |
| nand_re_no | output | 1 | Read strobe, active low |
| nand_io_o | output | 8 | Data bus out |
| nand_io_oe_o | output | 1 | Data bus output enable |
| nand_io_i | input | 8 | Data bus in |
| nand_rb_ni | input | 1 | Ready/busy pin, low = busy |

## Verification
On every cycle, the assertions check the bus-level rules: the latch enables are exclusive, the strobes are exclusive, and the bus is released during reads. They also check the shape of the handshake: `done_o` lasts one cycle, `busy_o` is held until `done_o`, and `fail_o` is stable while idle. The byte order of the sequence, the masking of the low row bits, the ready/busy ordering in pin mode, the poll spacing, and the choice of the status byte that sets `fail_o` all span many bus transfers. Only the bench's device model shows these. It sweeps both modes, both results, several addresses, busy times and poll gaps, and injects starts in the middle of an operation.

// File: rtl/erase_pkg.sv
package erase_pkg;
  localparam logic [7:0] CMD_SETUP  = 8'h60;
  localparam logic [7:0] CMD_GO     = 8'hD0;
  localparam logic [7:0] CMD_STATUS = 8'h70;
  localparam int unsigned ST_READY_BIT = 6;
  localparam int unsigned ST_FAIL_BIT  = 0;

  typedef enum logic [1:0] {XF_CMD, XF_ADDR, XF_READ} xfer_e;

  typedef enum logic [3:0] {
    S_IDLE, S_SETUP, S_ADDR, S_GO, S_WAIT_LO, S_WAIT_HI,
    S_GAP, S_ST_CMD, S_ST_RD, S_FINISH
  } seq_state_e;
endpackage

// File: rtl/nand_bus_phy.sv
module nand_bus_phy
  import erase_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  xfer_e      kind_i,
  input  logic [7:0] wdata_i,
  output logic       ack_o,
  output logic [7:0] rdata_o,
  output logic       cle_o,
  output logic       ale_o,
  output logic       we_no,
  output logic       re_no,
  output logic [7:0] io_o,
  output logic       io_oe_o,
  input  logic [7:0] io_i
);
  logic [1:0] ph_q;

  // phase 1: strobe low, phase 2: strobe high, phase 0: latches dropped + ack
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= '0;
      cle_o   <= 1'b0;
      ale_o   <= 1'b0;
      we_no   <= 1'b1;
      re_no   <= 1'b1;
      io_o    <= '0;
      io_oe_o <= 1'b0;
      ack_o   <= 1'b0;
      rdata_o <= '0;
    end else begin
      ack_o <= 1'b0;
      case (ph_q)
        2'd0: if (req_i && !ack_o) begin
          cle_o   <= (kind_i == XF_CMD);
          ale_o   <= (kind_i == XF_ADDR);
          io_oe_o <= (kind_i != XF_READ);
          io_o    <= wdata_i;
          we_no   <= (kind_i == XF_READ);
          re_no   <= (kind_i != XF_READ);
          ph_q    <= 2'd1;
        end
        2'd1: begin
          we_no <= 1'b1;
          re_no <= 1'b1;
          if (!re_no) rdata_o <= io_i;
          ph_q  <= 2'd2;
        end
        2'd2: begin
          cle_o   <= 1'b0;
          ale_o   <= 1'b0;
          io_oe_o <= 1'b0;
          ack_o   <= 1'b1;
          ph_q    <= 2'd0;
        end
        default: ph_q <= 2'd0;
      endcase
    end
  end
endmodule

// File: rtl/gap_timer.sv
module gap_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] len_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= (len_i == '0) ? W'(1) : len_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - W'(1);
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/erase_seq.sv
module erase_seq
  import erase_pkg::*;
#(
  parameter int unsigned ADDR_CYC = 3,
  parameter int unsigned IGN_BITS = 6,
  parameter int unsigned GAP_W    = 8,
  localparam int unsigned ROW_W   = 8 * ADDR_CYC,
  localparam int unsigned IDX_W   = (ADDR_CYC > 1) ? $clog2(ADDR_CYC) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [ROW_W-1:0] row_addr_i,
  input  logic             mode_poll_i,
  input  logic [GAP_W-1:0] poll_gap_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             fail_o,
  output logic             nand_cle_o,
  output logic             nand_ale_o,
  output logic             nand_we_no,
  output logic             nand_re_no,
  output logic [7:0]       nand_io_o,
  output logic             nand_io_oe_o,
  input  logic [7:0]       nand_io_i,
  input  logic             nand_rb_ni
);
  localparam logic [ROW_W-1:0] LOW_MASK = ROW_W'((64'd1 << IGN_BITS) - 64'd1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ADDR_CYC - 1);

  seq_state_e       state_q;
  logic [ROW_W-1:0] row_q;
  logic [IDX_W-1:0] idx_q;
  logic [GAP_W-1:0] gap_q;
  logic             poll_q, fail_q;
  logic [1:0]       rb_sync_q;
  logic             rb_ready;

  logic       req, ack, tmr_load, tmr_exp;
  xfer_e      kind;
  logic [7:0] wdata, rdata;
  logic       st_ready, st_fail;

  assign st_ready = rdata[ST_READY_BIT];
  assign st_fail  = rdata[ST_FAIL_BIT];
  assign rb_ready = rb_sync_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rb_sync_q <= 2'b11;
    else         rb_sync_q <= {rb_sync_q[0], nand_rb_ni};
  end

  always_comb begin
    req   = 1'b0;
    kind  = XF_CMD;
    wdata = '0;
    case (state_q)
      S_SETUP:  begin req = 1'b1; wdata = CMD_SETUP; end
      S_ADDR:   begin req = 1'b1; kind = XF_ADDR; wdata = row_q[8*idx_q +: 8]; end
      S_GO:     begin req = 1'b1; wdata = CMD_GO; end
      S_ST_CMD: begin req = 1'b1; wdata = CMD_STATUS; end
      S_ST_RD:  begin req = 1'b1; kind = XF_READ; end
      default:  ;
    endcase
  end

  assign tmr_load = poll_q && ack &&
                    ((state_q == S_GO) || (state_q == S_ST_RD && !st_ready));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      row_q   <= '0;
      idx_q   <= '0;
      gap_q   <= '0;
      poll_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (start_i) begin
          row_q   <= row_addr_i & ~LOW_MASK;
          poll_q  <= mode_poll_i;
          gap_q   <= poll_gap_i;
          fail_q  <= 1'b0;
          state_q <= S_SETUP;
        end
        S_SETUP: if (ack) begin idx_q <= '0; state_q <= S_ADDR; end
        S_ADDR: if (ack) begin
          if (idx_q == LAST_IDX) state_q <= S_GO;
          else                   idx_q   <= idx_q + IDX_W'(1);
        end
        S_GO:      if (ack) state_q <= poll_q ? S_GAP : S_WAIT_LO;
        S_WAIT_LO: if (!rb_ready) state_q <= S_WAIT_HI;
        S_WAIT_HI: if (rb_ready)  state_q <= S_ST_CMD;
        S_GAP:     if (tmr_exp)   state_q <= S_ST_CMD;
        S_ST_CMD:  if (ack)       state_q <= S_ST_RD;
        S_ST_RD: if (ack) begin
          if (!poll_q || st_ready) begin
            fail_q  <= st_fail;
            state_q <= S_FINISH;
          end else begin
            state_q <= S_GAP;
          end
        end
        S_FINISH: state_q <= S_IDLE;
        default:  state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != S_IDLE);
  assign done_o = (state_q == S_FINISH);
  assign fail_o = fail_q;

  nand_bus_phy u_phy (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req),
    .kind_i  (kind),
    .wdata_i (wdata),
    .ack_o   (ack),
    .rdata_o (rdata),
    .cle_o   (nand_cle_o),
    .ale_o   (nand_ale_o),
    .we_no   (nand_we_no),
    .re_no   (nand_re_no),
    .io_o    (nand_io_o),
    .io_oe_o (nand_io_oe_o),
    .io_i    (nand_io_i)
  );

  gap_timer #(.W(GAP_W)) u_gap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .len_i     (gap_q),
    .expired_o (tmr_exp)
  );
endmodule

// File: rtl/erase_seq_chk.sv
module erase_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic fail_o,
  input logic nand_cle_o,
  input logic nand_ale_o,
  input logic nand_we_no,
  input logic nand_re_no,
  input logic nand_io_oe_o
);
  // R10
  latch_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(nand_cle_o && nand_ale_o));
  // R10
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!nand_we_no && !nand_re_no));
  // R10
  bus_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nand_re_no |-> !nand_io_oe_o);
  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R8
  done_in_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);
  // R9
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);
  // R8
  busy_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(done_o));
  // R7
  fail_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(fail_o));
endmodule

bind erase_seq erase_seq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .fail_o       (fail_o),
  .nand_cle_o   (nand_cle_o),
  .nand_ale_o   (nand_ale_o),
  .nand_we_no   (nand_we_no),
  .nand_re_no   (nand_re_no),
  .nand_io_oe_o (nand_io_oe_o)
);

// File: tb/sim_erase_seq.sv
module sim_erase_seq;
  localparam int CLK_PERIOD = 10;
  localparam int LOG_N = 4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] row = '0;
  logic        mode = 1'b0;
  logic [7:0]  gap = '0;
  logic        busy, done, fail;
  logic        cle, ale, we_n, re_n, io_oe;
  logic [7:0]  io_o, io_i;
  logic        rb_n;

  int checks = 0, fails = 0;
  bit finished = 0;

  int  cyc = 0;
  logic [9:0] log_q [LOG_N];
  int  log_n = 0, stat_cmds = 0, rb_viol = 0, gap_viol = 0, conf_req = 0;
  int  conf_seen = 0, busy_cnt = 0, last_rd_cyc = 0;
  bit  last_ready = 1;
  int  cur_bers = 6, cur_gap = 1;
  logic cur_fail = 1'b0, cur_poll = 1'b0;
  logic dev_ready;

  always #(CLK_PERIOD/2) clk = ~clk;

  erase_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .row_addr_i(row),
    .mode_poll_i(mode), .poll_gap_i(gap), .busy_o(busy), .done_o(done),
    .fail_o(fail), .nand_cle_o(cle), .nand_ale_o(ale), .nand_we_no(we_n),
    .nand_re_no(re_n), .nand_io_o(io_o), .nand_io_oe_o(io_oe),
    .nand_io_i(io_i), .nand_rb_ni(rb_n)
  );

  // device model: busy for cur_bers cycles after confirm; status bit 0 inverted while busy
  assign dev_ready = (busy_cnt == 0);
  assign rb_n = dev_ready;
  assign io_i = dev_ready ? {1'b0, 1'b1, 5'b0, cur_fail} : {7'b0, ~cur_fail};

  always @(posedge clk) begin
    cyc++;
    if (conf_seen != conf_req) begin conf_seen = conf_req; busy_cnt = cur_bers; end
    else if (busy_cnt > 0) busy_cnt--;
  end

  always @(posedge we_n) begin
    if (log_n < LOG_N) log_q[log_n] = {cle, ale, io_o};
    log_n++;
    if (cle && io_o == 8'h70) begin
      stat_cmds++;
      if (!dev_ready) rb_viol++;
      if (!last_ready && (cyc - last_rd_cyc) < cur_gap) gap_viol++;
    end
    if (cle && io_o == 8'hD0) conf_req++;
  end

  always @(posedge re_n) begin
    last_rd_cyc = cyc;
    last_ready  = dev_ready;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic run_op(input logic [23:0] addr, input logic poll, input logic [7:0] g,
                        input int bers, input logic f, input bit inject);
    int base, sc0, rv0, gv0, nd, n, setups, nstat;
    logic fs;
    logic [23:0] exp_row;
    cur_bers = bers; cur_fail = f; cur_poll = poll;
    cur_gap  = (g == 0) ? 1 : int'(g);
    base = log_n; sc0 = stat_cmds; rv0 = rb_viol; gv0 = gap_viol;
    last_ready = 1;
    @(negedge clk);
    row = addr; mode = poll; gap = g; start = 1'b1;
    @(negedge clk);
    start = 1'b0; row = ~addr; mode = ~poll; gap = 8'd200;
    chk(busy === 1'b1, "R8 busy after start", busy, 1);
    nd = 0; fs = 1'bx;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      start = (inject && (i == 15 || i == 40)) ? 1'b1 : 1'b0;
      if (done) begin nd++; fs = fail; end
      if (!busy) break;
    end
    start = 1'b0;
    chk(nd == 1, "R8 single done pulse", nd, 1);
    chk(fs === f, "R7 fail at done", fs, f);
    @(negedge clk); @(negedge clk);
    chk(busy === 1'b0, "R9 no second operation", busy, 0);
    chk(fail === f, "R7 fail held", fail, f);
    n = log_n - base;
    nstat = stat_cmds - sc0;
    exp_row = addr & ~24'h3F;
    chk(log_q[base] === {2'b10, 8'h60}, "R1 setup command", log_q[base], {2'b10, 8'h60});
    for (int k = 0; k < 3; k++) begin
      chk(log_q[base+1+k] === {2'b01, exp_row[8*k +: 8]}, "R2 address byte",
          log_q[base+1+k], {2'b01, exp_row[8*k +: 8]});
    end
    chk(log_q[base+1][5:0] === 6'b0, "R3 low row bits zero", log_q[base+1][5:0], 0);
    chk(log_q[base+4] === {2'b10, 8'hD0}, "R4 confirm after address", log_q[base+4], {2'b10, 8'hD0});
    chk(n == 5 + nstat, "R4 only status after confirm", n, 5 + nstat);
    setups = 0;
    for (int k = 0; k < n; k++) if (log_q[base+k] === {2'b10, 8'h60}) setups++;
    chk(setups == 1, "R9 one setup per operation", setups, 1);
    if (!poll) begin
      chk(nstat == 1, "R5 one status read", nstat, 1);
      chk(rb_viol == rv0, "R5 status only when ready", rb_viol - rv0, 0);
    end else begin
      chk(nstat >= 1, "R6 status polled", nstat, 1);
      if (bers >= 40 && cur_gap <= 5)
        chk(nstat >= 2, "R6 repeated poll while busy", nstat, 2);
      chk(gap_viol == gv0, "R6 poll spacing", gap_viol - gv0, 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
  end

  initial begin
    logic [23:0] addrs [4];
    addrs[0] = 24'hA5C3FF; addrs[1] = 24'h000040;
    addrs[2] = 24'hFFFFFF; addrs[3] = 24'h12345F;
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R8 reset outputs", {busy, done}, 0);
    chk(we_n === 1'b1 && re_n === 1'b1 && cle === 1'b0 && ale === 1'b0,
        "R10 reset bus", {we_n, re_n, cle, ale}, 4'b1100);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int m = 0; m < 2; m++)
      for (int f = 0; f < 2; f++)
        for (int a = 0; a < 4; a++)
          for (int b = 0; b < 2; b++) begin
            logic [7:0] g;
            g = (a == 2) ? 8'd0 : ((a % 2) ? 8'd1 : 8'd5);
            run_op(addrs[a], m[0], g, (b == 0) ? 6 : 40, f[0], a == 1);
          end
    summary();
  end
endmodule